// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps track of a shared packet buffer for a network controller. The buffer is split into fixed 2 KB pages, and each page has exactly one packet number: the number of the page it occupies. The host asks for buffer space with an allocate command and gets the packet number back in a result register. The receive engine asks for pages through its own request port. Both sides give pages back to one common pool. A free-memory counter reports the remaining space in 512-byte units.

Two packet-number FIFOs sit next to the pool. The transmit queue is filled by a host enqueue command and drained by the transmit engine. The receive queue is filled by the receive engine when a frame has been stored, and the host drains it. The host can reserve part of the pool for transmit. The receive engine cannot allocate into that reserve. Every command takes effect at the clock edge that samples it, so all results are visible from the next cycle.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset `free_units_o` is 256, both queues are empty, `alloc_res_o` is 80h, and `alloc_irq_o` and `rx_irq_o` are low.
- R2: A host allocate (op 1) with a free page sets `alloc_res_o` to the lowest free page number, with bit 7 clear, in the next cycle, and lowers `free_units_o` by 4. `cmd_arg_i` has no effect on the result.
- R3: A host allocate with no free page sets `alloc_res_o` to 80h (bit 7 is the failure flag), leaves `free_units_o` unchanged and raises no interrupt.
- R4: `alloc_irq_o` is high for one cycle after a successful host allocate, and only when `alloc_irq_en_i` was high with that command.
- R5: Release (op 5) of an allocated packet number raises `free_units_o` by 4. Release of a packet number that is already free changes nothing.
- R6: A receive-engine request succeeds only when the number of free pages exceeds the reserved pages. The reserved pages are `tx_reserve_i` shifted right by 2, or the whole pool when `tx_reserve_i` is FFh. The result pulses on `mac_rx_ok_o` (with `mac_rx_pkt_o`) or on `mac_rx_fail_o` one cycle later.
- R7: When a host allocate and a receive-engine request arrive in the same cycle, the host is served and the receive engine gets `mac_rx_fail_o`.
- R8: `mac_rx_commit_i` appends a packet number to the receive queue. `rx_head_o` shows the oldest entry without popping it. `rx_irq_o` always equals the inverse of `rx_empty_o`.
- R9: Remove-and-release (op 4) pops the receive head and frees its page. On an empty receive queue it has no effect.
- R10: Enqueue (op 6) appends `cmd_arg_i` to the transmit queue. `mac_tx_pop_i` removes the head, in FIFO order.
- R11: Transmit flush (op 7) empties the transmit queue and leaves `free_units_o` unchanged.
- R12: Pool reset (op 2) restores `free_units_o` to 256, empties both queues and sets `alloc_res_o` to 80h. Allocation then starts again from page 0.
- R13: A receive-engine allocation and a remove-and-release in the same cycle leave `free_units_o` unchanged. The receive engine gets the lowest page that was free before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_op_i | input | 3 | Opcode: 1 allocate, 2 pool reset, 4 remove-and-release, 5 release, 6 enqueue, 7 transmit flush, others no-op |
| cmd_arg_i | input | 6 | Packet number for release and enqueue |
| alloc_irq_en_i | input | 1 | Enables the allocation interrupt |
| tx_reserve_i | input | 8 | Transmit reserve in 512-byte units |
| alloc_res_o | output | 8 | Allocation result: bit 7 failure, bits 5:0 packet number |
| alloc_irq_o | output | 1 | Allocation-success pulse |
| free_units_o | output | 9 | Free memory in 512-byte units |
| mac_rx_alloc_i | input | 1 | Receive-engine page request |
| mac_rx_ok_o | output | 1 | Receive request granted |
| mac_rx_fail_o | output | 1 | Receive request refused |
| mac_rx_pkt_o | output | 6 | Packet number granted to the receive engine |
| mac_rx_commit_i | input | 1 | Append a received packet to the receive queue |
| mac_rx_commit_pkt_i | input | 6 | Packet number to append |
| mac_tx_pop_i | input | 1 | Transmit engine consumes the transmit head |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_head_o | output | 6 | Transmit queue head |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_head_o | output | 6 | Receive queue head |
| rx_irq_o | output | 1 | Receive interrupt, set while the receive queue holds packets |

## Verification
The receive engine's page request can arrive in the same cycle as a host command that also touches the pool. Two such collisions are exercised. First, a host allocate and a receive request are driven together. The host must receive the lowest free page, the receive engine must get a fail pulse, and the counter must drop by exactly one page. Second, a remove-and-release is driven together with a receive request. The receive engine must get the lowest page that was free before the release, the counter must not move, and the receive head must advance.

// File: rtl/pba_pkg.sv
package pba_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_ALLOC    = 3'd1,
    OP_RESET    = 3'd2,
    OP_SPARE    = 3'd3,
    OP_RX_DROP  = 3'd4,
    OP_RELEASE  = 3'd5,
    OP_TX_ENQ   = 3'd6,
    OP_TX_FLUSH = 3'd7
  } pba_op_e;
endpackage

// File: rtl/pba_first_free.sv
module pba_first_free #(
  parameter int N = 64,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  // scan high to low so the lowest set bit wins
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/pba_page_pool.sv
module pba_page_pool #(
  parameter int NUM_PAGES = 64,
  parameter int IDX_W     = $clog2(NUM_PAGES),
  parameter int CNT_W     = $clog2(NUM_PAGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             alloc_i,
  input  logic             free_i,
  input  logic [IDX_W-1:0] free_idx_i,
  output logic             any_free_o,
  output logic [IDX_W-1:0] alloc_idx_o,
  output logic [CNT_W-1:0] free_pages_o
);
  logic [NUM_PAGES-1:0] free_map_q, free_map_d;
  logic [CNT_W-1:0]     cnt_q;
  logic                 alloc_ok, free_ok;

  pba_first_free #(.N(NUM_PAGES), .W(IDX_W)) u_find (
    .vec_i  (free_map_q),
    .found_o(any_free_o),
    .idx_o  (alloc_idx_o)
  );

  assign alloc_ok = alloc_i && any_free_o;
  assign free_ok  = free_i && !free_map_q[free_idx_i];

  always_comb begin
    free_map_d = free_map_q;
    if (alloc_ok) free_map_d[alloc_idx_o] = 1'b0;
    if (free_ok)  free_map_d[free_idx_i]  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_map_q <= '1;
      cnt_q      <= CNT_W'(NUM_PAGES);
    end else if (clear_i) begin
      free_map_q <= '1;
      cnt_q      <= CNT_W'(NUM_PAGES);
    end else begin
      free_map_q <= free_map_d;
      case ({free_ok, alloc_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign free_pages_o = cnt_q;
endmodule

// File: rtl/pba_pktq.sv
module pba_pktq #(
  parameter int DEPTH = 64,
  parameter int DW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wp_q, rp_q;
  logic          full, push_ok, pop_ok;

  assign empty_o = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign push_ok = push_i && !full && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_ok) wp_q <= wp_q + (AW+1)'(1);
      if (pop_ok)  rp_q <= rp_q + (AW+1)'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q[AW-1:0]] <= din_i;
  end

  assign head_o = mem_q[rp_q[AW-1:0]];
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pba_pkg::*;
#(
  parameter int NUM_PAGES      = 64,
  parameter int UNITS_PER_PAGE = 4,
  parameter int RES_W          = 8,
  localparam int PKT_W  = $clog2(NUM_PAGES),
  localparam int CNT_W  = $clog2(NUM_PAGES + 1),
  localparam int FREE_W = $clog2(NUM_PAGES * UNITS_PER_PAGE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [PKT_W-1:0]  cmd_arg_i,
  input  logic              alloc_irq_en_i,
  input  logic [RES_W-1:0]  tx_reserve_i,
  output logic [RES_W-1:0]  alloc_res_o,
  output logic              alloc_irq_o,
  output logic [FREE_W-1:0] free_units_o,
  input  logic              mac_rx_alloc_i,
  output logic              mac_rx_ok_o,
  output logic              mac_rx_fail_o,
  output logic [PKT_W-1:0]  mac_rx_pkt_o,
  input  logic              mac_rx_commit_i,
  input  logic [PKT_W-1:0]  mac_rx_commit_pkt_i,
  input  logic              mac_tx_pop_i,
  output logic              tx_empty_o,
  output logic [PKT_W-1:0]  tx_head_o,
  output logic              rx_empty_o,
  output logic [PKT_W-1:0]  rx_head_o,
  output logic              rx_irq_o
);
  localparam int UPP_SH = $clog2(UNITS_PER_PAGE);
  localparam logic [RES_W-1:0] RES_FAIL = RES_W'(1) << (RES_W - 1);

  logic cmd_alloc, cmd_reset, cmd_rx_drop, cmd_release, cmd_tx_enq, cmd_tx_flush;
  logic any_free, host_ok, mac_ok, rx_pop, pool_free;
  logic [PKT_W-1:0] alloc_idx, pool_free_idx;
  logic [CNT_W-1:0] free_pages, res_pages;
  logic [RES_W-1:0] alloc_res_q;
  logic             alloc_irq_q, mac_ok_q, mac_fail_q;
  logic [PKT_W-1:0] mac_pkt_q;

  assign cmd_alloc    = cmd_valid_i && (cmd_op_i == OP_ALLOC);
  assign cmd_reset    = cmd_valid_i && (cmd_op_i == OP_RESET);
  assign cmd_rx_drop  = cmd_valid_i && (cmd_op_i == OP_RX_DROP);
  assign cmd_release  = cmd_valid_i && (cmd_op_i == OP_RELEASE);
  assign cmd_tx_enq   = cmd_valid_i && (cmd_op_i == OP_TX_ENQ);
  assign cmd_tx_flush = cmd_valid_i && (cmd_op_i == OP_TX_FLUSH);

  // an all-ones reserve takes the whole pool, otherwise whole pages only
  assign res_pages = (&tx_reserve_i) ? CNT_W'(NUM_PAGES)
                                     : CNT_W'(tx_reserve_i >> UPP_SH);

  assign host_ok = cmd_alloc && any_free;
  // host command owns the pool this cycle; receive side retries
  assign mac_ok  = mac_rx_alloc_i && !cmd_alloc && !cmd_reset &&
                   (free_pages > res_pages);

  assign rx_pop        = cmd_rx_drop && !rx_empty_o;
  assign pool_free     = cmd_release || rx_pop;
  assign pool_free_idx = cmd_release ? cmd_arg_i : rx_head_o;

  pba_page_pool #(.NUM_PAGES(NUM_PAGES), .IDX_W(PKT_W), .CNT_W(CNT_W)) u_pool (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (cmd_reset),
    .alloc_i     (host_ok || mac_ok),
    .free_i      (pool_free),
    .free_idx_i  (pool_free_idx),
    .any_free_o  (any_free),
    .alloc_idx_o (alloc_idx),
    .free_pages_o(free_pages)
  );

  pba_pktq #(.DEPTH(NUM_PAGES), .DW(PKT_W)) u_txq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(cmd_reset || cmd_tx_flush),
    .push_i (cmd_tx_enq),
    .din_i  (cmd_arg_i),
    .pop_i  (mac_tx_pop_i),
    .head_o (tx_head_o),
    .empty_o(tx_empty_o)
  );

  pba_pktq #(.DEPTH(NUM_PAGES), .DW(PKT_W)) u_rxq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(cmd_reset),
    .push_i (mac_rx_commit_i),
    .din_i  (mac_rx_commit_pkt_i),
    .pop_i  (rx_pop),
    .head_o (rx_head_o),
    .empty_o(rx_empty_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_res_q <= RES_FAIL;
      alloc_irq_q <= 1'b0;
      mac_ok_q    <= 1'b0;
      mac_fail_q  <= 1'b0;
      mac_pkt_q   <= '0;
    end else begin
      alloc_irq_q <= host_ok && alloc_irq_en_i;
      mac_ok_q    <= mac_ok;
      mac_fail_q  <= mac_rx_alloc_i && !mac_ok;
      if (mac_ok) mac_pkt_q <= alloc_idx;
      if (cmd_reset)
        alloc_res_q <= RES_FAIL;
      else if (cmd_alloc)
        alloc_res_q <= host_ok ? RES_W'(alloc_idx) : RES_FAIL;
    end
  end

  assign alloc_res_o   = alloc_res_q;
  assign alloc_irq_o   = alloc_irq_q;
  assign mac_rx_ok_o   = mac_ok_q;
  assign mac_rx_fail_o = mac_fail_q;
  assign mac_rx_pkt_o  = mac_pkt_q;
  assign free_units_o  = FREE_W'(free_pages) << UPP_SH;
  assign rx_irq_o      = !rx_empty_o;
endmodule

module pkt_page_alloc_chk
  import pba_pkg::*;
#(
  parameter int NUM_PAGES      = 64,
  parameter int UNITS_PER_PAGE = 4,
  parameter int RES_W          = 8,
  parameter int FREE_W         = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_op_i,
  input logic              alloc_irq_en_i,
  input logic [RES_W-1:0]  tx_reserve_i,
  input logic              mac_rx_alloc_i,
  input logic [RES_W-1:0]  alloc_res_o,
  input logic              alloc_irq_o,
  input logic [FREE_W-1:0] free_units_o,
  input logic              mac_rx_ok_o,
  input logic              tx_empty_o,
  input logic              rx_empty_o,
  input logic              rx_irq_o
);
  localparam int TOTAL  = NUM_PAGES * UNITS_PER_PAGE;
  localparam int UPP_SH = $clog2(UNITS_PER_PAGE);

  function automatic int res_units(logic [RES_W-1:0] r);
    if (&r) return TOTAL;
    return int'(r >> UPP_SH) << UPP_SH;
  endfunction

  a_r1_free_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(free_units_o) <= TOTAL);

  a_r8_rx_irq_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o == !rx_empty_o);

  a_r4_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_irq_o |-> $past(cmd_valid_i && cmd_op_i == OP_ALLOC && alloc_irq_en_i));

  a_r3_fail_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_res_o[RES_W-1] && $past(cmd_valid_i && cmd_op_i == OP_ALLOC))
    |-> (!alloc_irq_o && free_units_o == $past(free_units_o)));

  a_r2_alloc_takes_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_res_o[RES_W-1] && $past(cmd_valid_i && cmd_op_i == OP_ALLOC))
    |-> (int'(free_units_o) == int'($past(free_units_o)) - UNITS_PER_PAGE));

  a_r6_rx_reserve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_rx_ok_o |-> (int'($past(free_units_o)) > res_units($past(tx_reserve_i))));

  a_r7_host_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_rx_ok_o |-> !$past(cmd_valid_i && cmd_op_i == OP_ALLOC));

  a_r11_flush_keeps_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_valid_i && cmd_op_i == OP_TX_FLUSH && !mac_rx_alloc_i)
    |-> (tx_empty_o && free_units_o == $past(free_units_o)));

  a_r12_pool_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_valid_i && cmd_op_i == OP_RESET)
    |-> (int'(free_units_o) == TOTAL && rx_empty_o && tx_empty_o));
endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(
  .NUM_PAGES(NUM_PAGES), .UNITS_PER_PAGE(UNITS_PER_PAGE),
  .RES_W(RES_W), .FREE_W(FREE_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_op_i      (cmd_op_i),
  .alloc_irq_en_i(alloc_irq_en_i),
  .tx_reserve_i  (tx_reserve_i),
  .mac_rx_alloc_i(mac_rx_alloc_i),
  .alloc_res_o   (alloc_res_o),
  .alloc_irq_o   (alloc_irq_o),
  .free_units_o  (free_units_o),
  .mac_rx_ok_o   (mac_rx_ok_o),
  .tx_empty_o    (tx_empty_o),
  .rx_empty_o    (rx_empty_o),
  .rx_irq_o      (rx_irq_o)
);

// File: tb/pkt_page_alloc_bench.sv
module pkt_page_alloc_bench;
  localparam int CLK_PERIOD = 10;

  localparam int S_RES = 0, S_FREE = 1, S_AIRQ = 2, S_RXOK = 3, S_RXFAIL = 4,
                 S_RXPKT = 5, S_RXE = 6, S_RXH = 7, S_RXIRQ = 8, S_TXE = 9,
                 S_TXH = 10;
  localparam logic [2:0] C_ALLOC = 3'd1, C_RESET = 3'd2, C_RXDROP = 3'd4,
                         C_REL = 3'd5, C_ENQ = 3'd6, C_FLUSH = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, irq_en = 0, rx_alloc = 0, rx_commit = 0, tx_pop = 0;
  logic [2:0] cmd_op = '0;
  logic [5:0] cmd_arg = '0, commit_pkt = '0;
  logic [7:0] reserve = '0;
  logic [7:0] alloc_res;
  logic       alloc_irq, rx_ok, rx_fail, tx_empty, rx_empty, rx_irq;
  logic [8:0] free_units;
  logic [5:0] rx_pkt, tx_head, rx_head;

  pkt_page_alloc u_pkt_page_alloc (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_arg_i(cmd_arg), .alloc_irq_en_i(irq_en), .tx_reserve_i(reserve),
    .alloc_res_o(alloc_res), .alloc_irq_o(alloc_irq), .free_units_o(free_units),
    .mac_rx_alloc_i(rx_alloc), .mac_rx_ok_o(rx_ok), .mac_rx_fail_o(rx_fail),
    .mac_rx_pkt_o(rx_pkt), .mac_rx_commit_i(rx_commit),
    .mac_rx_commit_pkt_i(commit_pkt), .mac_tx_pop_i(tx_pop),
    .tx_empty_o(tx_empty), .tx_head_o(tx_head), .rx_empty_o(rx_empty),
    .rx_head_o(rx_head), .rx_irq_o(rx_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {int due; int sel; int val; string tag;} exp_t;
  exp_t exp_q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] busy = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int obs(int sel);
    case (sel)
      S_RES:    return int'(alloc_res);
      S_FREE:   return int'(free_units);
      S_AIRQ:   return int'(alloc_irq);
      S_RXOK:   return int'(rx_ok);
      S_RXFAIL: return int'(rx_fail);
      S_RXPKT:  return int'(rx_pkt);
      S_RXE:    return int'(rx_empty);
      S_RXH:    return int'(rx_head);
      S_RXIRQ:  return int'(rx_irq);
      S_TXE:    return int'(tx_empty);
      default:  return int'(tx_head);
    endcase
  endfunction

  // monitor: compare due expectations shortly after each edge
  always @(posedge clk) begin
    #2;
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      int got;
      e = exp_q.pop_front();
      got = obs(e.sel);
      checks++;
      if (got != e.val) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", e.tag, e.sel, got, e.val);
      end
    end
  end

  task automatic ex(int sel, int val, string tag);
    exp_q.push_back('{cyc + 1, sel, val, tag});
  endtask

  task automatic step();
    @(negedge clk);
    cmd_valid = 0; rx_alloc = 0; rx_commit = 0; tx_pop = 0;
  endtask

  task automatic cmd(logic [2:0] op, logic [5:0] arg);
    cmd_valid = 1; cmd_op = op; cmd_arg = arg;
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < 64; i++) if (!busy[i]) return i;
    return -1;
  endfunction

  function automatic int free_model();
    return 256 - 4 * $countones(busy);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    ex(S_RES, 8'h80, "R1"); ex(S_FREE, 256, "R1"); ex(S_RXE, 1, "R1");
    ex(S_TXE, 1, "R1"); ex(S_AIRQ, 0, "R1"); ex(S_RXIRQ, 0, "R1");
    step();
    // R2 / R4: allocate with interrupt enabled, argument ignored
    irq_en = 1; cmd(C_ALLOC, 6'h2A);
    ex(S_RES, 0, "R2"); ex(S_FREE, 252, "R2"); ex(S_AIRQ, 1, "R4");
    busy[0] = 1; step();
    irq_en = 0; cmd(C_ALLOC, 6'h15);
    ex(S_RES, 1, "R2"); ex(S_FREE, 248, "R2"); ex(S_AIRQ, 0, "R4");
    busy[1] = 1; step();
    // R5 release and double release
    cmd(C_REL, 6'd0); ex(S_FREE, 252, "R5"); busy[0] = 0; step();
    cmd(C_REL, 6'd0); ex(S_FREE, 252, "R5"); step();
    cmd(C_ALLOC, 6'd0); ex(S_RES, 0, "R2"); busy[0] = 1; step();
    // R10 transmit queue order
    cmd(C_ENQ, 6'd1); ex(S_TXE, 0, "R10"); ex(S_TXH, 1, "R10"); step();
    cmd(C_ENQ, 6'd0); ex(S_TXH, 1, "R10"); step();
    tx_pop = 1; ex(S_TXH, 0, "R10"); ex(S_TXE, 0, "R10"); step();
    cmd(C_ENQ, 6'd1); step();
    // R11 flush keeps memory
    cmd(C_FLUSH, 6'd0); ex(S_TXE, 1, "R11"); ex(S_FREE, 248, "R11"); step();
    // R6 reserve rules
    reserve = 8'hFF; rx_alloc = 1;
    ex(S_RXFAIL, 1, "R6"); ex(S_RXOK, 0, "R6"); step();
    reserve = 8'hF0; rx_alloc = 1;
    ex(S_RXOK, 1, "R6"); ex(S_RXPKT, 2, "R6"); busy[2] = 1; step();
    rx_alloc = 1; ex(S_RXOK, 1, "R6"); ex(S_RXPKT, 3, "R6"); busy[3] = 1; step();
    rx_alloc = 1; ex(S_RXFAIL, 1, "R6"); ex(S_FREE, 240, "R6"); step();
    reserve = 8'h00;
    // R7 collision: host wins
    cmd(C_ALLOC, 6'd9); rx_alloc = 1;
    ex(S_RES, 4, "R7"); ex(S_RXFAIL, 1, "R7"); ex(S_RXOK, 0, "R7");
    ex(S_FREE, 236, "R7"); busy[4] = 1; step();
    // R8 receive queue
    rx_commit = 1; commit_pkt = 6'd2;
    ex(S_RXE, 0, "R8"); ex(S_RXIRQ, 1, "R8"); ex(S_RXH, 2, "R8"); step();
    rx_commit = 1; commit_pkt = 6'd3; ex(S_RXH, 2, "R8"); step();
    // R13 drop and receive allocation together
    cmd(C_RXDROP, 6'd0); rx_alloc = 1;
    ex(S_RXOK, 1, "R13"); ex(S_RXPKT, 5, "R13"); ex(S_FREE, 236, "R13");
    ex(S_RXH, 3, "R13"); busy[5] = 1; busy[2] = 0; step();
    // R9 drop to empty, then drop on empty
    cmd(C_RXDROP, 6'd0);
    ex(S_RXE, 1, "R9"); ex(S_RXIRQ, 0, "R8"); ex(S_FREE, 240, "R9");
    busy[3] = 0; step();
    cmd(C_RXDROP, 6'd0); ex(S_RXE, 1, "R9"); ex(S_FREE, 240, "R9"); step();
    // R2 fill the pool, lowest page each time
    for (int k = 0; k < 60; k++) begin
      int p;
      p = lowest_free();
      cmd(C_ALLOC, 6'(k));
      ex(S_RES, p, "R2");
      busy[p] = 1;
      step();
    end
    ex(S_FREE, free_model(), "R2"); step();
    // R3 exhausted pool
    irq_en = 1; cmd(C_ALLOC, 6'd0);
    ex(S_RES, 8'h80, "R3"); ex(S_FREE, 0, "R3"); ex(S_AIRQ, 0, "R3"); step();
    irq_en = 0; rx_alloc = 1; ex(S_RXFAIL, 1, "R6"); step();
    // R12 pool reset
    cmd(C_ENQ, 6'd7); step();
    rx_commit = 1; commit_pkt = 6'd9; step();
    cmd(C_RESET, 6'd0);
    ex(S_FREE, 256, "R12"); ex(S_RXE, 1, "R12"); ex(S_TXE, 1, "R12");
    ex(S_RES, 8'h80, "R12"); busy = '0; step();
    cmd(C_ALLOC, 6'd0); ex(S_RES, 0, "R12"); ex(S_FREE, 252, "R12"); step();
    repeat (3) step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule